// File: doc/BRIEF.md
# Push-Button Debouncer

This block turns the chattering level from a mechanical push-button into a clean, stable level that the rest of the chip can use. Contacts bounce for several milliseconds whenever a button is pressed or let go. The block therefore reports a new level only after the input has held that level for a full settle interval. The same filter is applied to presses and to releases, and the output keeps the input's polarity. A button that reads 0 when pressed gives an output that reads 0 when pressed.

The raw pin first passes through a short synchronizer chain. The synchronized sample is then compared with a stored copy of the last sample. Any difference refreshes the stored copy and restarts a stable-time counter from zero. While the two agree, the counter climbs toward a terminal value and holds there. The output register takes the stored level on a cycle where the counter is at its terminal value and the input still agrees. By default the terminal value is 999999, which is a 10 ms interval at 100 MHz held in a 20-bit counter. Because it is a parameter, short intervals can be used in simulation.

Top module: `btn_debounce`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `btn_clean` equals the parameter `RESET_LEVEL`. The synchronizer and the stored sample are also preset to `RESET_LEVEL`.
- R2: `btn_raw` passes through `SYNC_STAGES` flip-flops before comparison. `SYNC_STAGES` is 0 (no flops) or 2 to 4. A level change that is then held changes `btn_clean` exactly `SYNC_STAGES + SETTLE_LAST + 2` rising clock edges after it is first sampled.
- R3: Any difference between the synchronized sample and the stored sample reloads the stored sample and restarts the stable count at zero. After a burst of bounces, the latency in R2 is counted from the last change.
- R4: A new level is accepted only if it is sampled on at least `SETTLE_LAST + 2` consecutive rising edges. A level held for fewer edges leaves `btn_clean` unchanged.
- R5: Presses and releases are filtered identically. Both the 1-to-0 and the 0-to-1 directions follow R2 and R4.
- R6: `btn_clean` never inverts the input. Once accepted, it equals the level that `btn_raw` held.
- R7: The stable counter stops at `SETTLE_LAST` and does not wrap. `btn_clean` stays constant under a steady input of any length, and the next change still has the latency given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw, bouncing button level (asynchronous to `clk`) |
| btn_clean | output | 1 | Debounced button level, same polarity as the input |

## Verification
The bench builds two instances. The first has a settle terminal of 5, a two-flop synchronizer and a high reset level. The second has a terminal of 3, no synchronizer and a low reset level. Both sets of variant logic are exercised, together with both reset polarities. The short terminals make it practical to sweep every pulse width from a single cycle to past the acceptance threshold, in both directions. Each width is checked against the exact edge where the output should move and the exact edge where it should move back. The short terminals also make hold times longer than the counter's wrap range cheap to run. This gives the saturation behaviour, bounce bursts and a reset taken in the middle of operation, all within a few thousand cycles.

// File: rtl/btn_dbn_pkg.sv
package btn_dbn_pkg;

   // Deepest synchronizer chain the block accepts.
   localparam int unsigned DBN_MAX_SYNC = 4;

   // Bits needed to hold every value from 0 to last (never fewer than 1).
   function automatic int unsigned dbn_cnt_bits(input longint unsigned last);
      int unsigned b;
      b = 1;
      while (b < 63 && ((64'd1 << b) <= last)) b++;
      return b;
   endfunction

endpackage

// File: rtl/btn_dbn_sync.sv
module btn_dbn_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (rst) stage_q[i] <= RST_VAL;
                  else     stage_q[i] <= din;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (rst) stage_q[i] <= RST_VAL;
                  else     stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign dout = stage_q[STAGES-1];

         // R2: the chain's output is the input delayed through the flops.
         if (STAGES >= 2) begin : g_chk
            a_r2_chain_shift: assert property (@(posedge clk) disable iff (rst)
               !$past(rst) |-> (stage_q[1] == $past(stage_q[0])));
         end
      end
   endgenerate

endmodule

// File: rtl/btn_dbn_timer.sv
module btn_dbn_timer
   import btn_dbn_pkg::*;
#(
   parameter int unsigned LAST = 999999
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic expired
);

   localparam int unsigned    W      = dbn_cnt_bits(LAST);
   localparam logic [W-1:0]   LAST_V = W'(LAST);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || restart)       cnt_q <= '0;
      else if (cnt_q != LAST_V) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LAST_V);

   // R3: a restart request always leaves the count at zero.
   a_r3_restart_zero: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt_q == '0));

   // R4: a stable input advances the count by exactly one below the terminal.
   a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
      (!restart && !expired) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R7: at the terminal value the count holds instead of wrapping.
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (!restart && expired) |=> expired);

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce
   import btn_dbn_pkg::*;
#(
   parameter int unsigned SETTLE_LAST = 999999,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic btn_clean
);

   generate
      if (SETTLE_LAST < 1) begin : g_bad_last
         $error("btn_debounce: SETTLE_LAST must be at least 1");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > DBN_MAX_SYNC) begin : g_bad_sync
         $error("btn_debounce: SYNC_STAGES must be 0 or 2..4");
      end
   endgenerate

   logic s_in;
   logic prev_q;
   logic clean_q;
   logic mismatch;
   logic tmr_expired;

   btn_dbn_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (RESET_LEVEL)
   ) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (btn_raw),
      .dout (s_in)
   );

   assign mismatch = s_in ^ prev_q;

   btn_dbn_timer #(
      .LAST (SETTLE_LAST)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (mismatch),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q  <= RESET_LEVEL;
         clean_q <= RESET_LEVEL;
      end else if (mismatch) begin
         prev_q  <= s_in;
      end else if (tmr_expired) begin
         clean_q <= prev_q;
      end
   end

   assign btn_clean = clean_q;

   // R1: reset forces the configured level onto the output.
   a_r1_reset_level: assert property (@(posedge clk)
      rst |=> (btn_clean == RESET_LEVEL));

   // R4: the output moves only after the stable count reached its terminal.
   a_r4_change_needs_expiry: assert property (@(posedge clk) disable iff (rst)
      !$stable(btn_clean) |-> $past(tmr_expired));

   // R3: the output never moves on a cycle that saw a fresh difference.
   a_r3_no_change_on_diff: assert property (@(posedge clk) disable iff (rst)
      !$stable(btn_clean) |-> !$past(mismatch));

   // R6: a new output level is the synchronized level, never its inverse.
   a_r6_same_polarity: assert property (@(posedge clk) disable iff (rst)
      !$stable(btn_clean) |-> (btn_clean == $past(s_in)));

endmodule

// File: tb/sim_btn_debounce.sv
`timescale 1ns/1ps
module sim_btn_debounce;

   localparam int T0 = 5;
   localparam int S0 = 2;
   localparam int T1 = 3;
   localparam int S1 = 0;
   localparam int L0 = S0 + T0 + 2;
   localparam int L1 = S1 + T1 + 2;
   localparam int H0 = T0 + 2;
   localparam int H1 = T1 + 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic raw0 = 1'b1;
   logic raw1 = 1'b0;
   logic clean0, clean1;
   int   nvec = 0;
   int   nfail = 0;
   bit   done = 0;

   always #2.5 clk = ~clk;

   btn_debounce #(.SETTLE_LAST(T0), .SYNC_STAGES(S0), .RESET_LEVEL(1'b1)) u0 (
      .clk(clk), .rst(rst), .btn_raw(raw0), .btn_clean(clean0));

   btn_debounce #(.SETTLE_LAST(T1), .SYNC_STAGES(S1), .RESET_LEVEL(1'b0)) u1 (
      .clk(clk), .rst(rst), .btn_raw(raw1), .btn_clean(clean1));

   function automatic logic out_of(input int k);
      return (k == 0) ? clean0 : clean1;
   endfunction
   function automatic int lat_of(input int k);
      return (k == 0) ? L0 : L1;
   endfunction
   function automatic int thr_of(input int k);
      return (k == 0) ? H0 : H1;
   endfunction

   task automatic set_raw(input int k, input logic v);
      if (k == 0) raw0 = v; else raw1 = v;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold(input int k, input logic v);
      set_raw(k, v);
      repeat (lat_of(k) + 6) @(negedge clk);
   endtask

   // Drive the opposite level for h edges, then return; record output moves.
   task automatic pulse_trial(input int k, input int h, input string req);
      logic base, po;
      int   first, back, extra, ef, eb;
      base = out_of(k); po = base;
      first = -1; back = -1; extra = 0;
      set_raw(k, ~base);
      for (int e = 1; e <= h + lat_of(k) + 6; e++) begin
         @(negedge clk);
         if (out_of(k) != po) begin
            if (first < 0) first = e;
            else if (back < 0) back = e;
            else extra++;
            po = out_of(k);
         end
         if (e == h) set_raw(k, base);
      end
      ef = (h >= thr_of(k)) ? lat_of(k) : -1;
      eb = (h >= thr_of(k)) ? h + lat_of(k) : -1;
      check(first == ef, req, first, ef);
      check(back == eb && extra == 0, req, back, eb);
   endtask

   // R3: bounce burst of short segments, then a steady level.
   task automatic bounce_trial(input int k);
      logic base, lvl;
      int   chg, e;
      base = out_of(k); lvl = ~base; chg = 0;
      for (int w = 1; w < thr_of(k); w++) begin
         set_raw(k, lvl);
         repeat (w) begin
            @(negedge clk);
            if (out_of(k) != base) chg++;
         end
         lvl = ~lvl;
      end
      if (lvl == base) begin
         set_raw(k, base);
         @(negedge clk);
         if (out_of(k) != base) chg++;
      end
      check(chg == 0, "R3 bounce rejected", chg, 0);
      set_raw(k, ~base);
      e = 0;
      while (out_of(k) == base && e < lat_of(k) + 10) begin
         @(negedge clk);
         e++;
      end
      check(e == lat_of(k), "R3 latency after last bounce", e, lat_of(k));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(clean0 == 1'b1, "R1 reset level u0", clean0, 1);
      check(clean1 == 1'b0, "R1 reset level u1", clean1, 0);
      rst = 1'b0;
      @(negedge clk);
      check(clean0 == 1'b1, "R1 after release u0", clean0, 1);
      check(clean1 == 1'b0, "R1 after release u1", clean1, 0);

      for (int k = 0; k < 2; k++) begin
         // Press direction 1 -> 0 (R4, R5).
         hold(k, 1'b1);
         check(out_of(k) == 1'b1, "R6 polarity high", out_of(k), 1);
         for (int h = 1; h <= thr_of(k) + 2; h++) pulse_trial(k, h, "R4 R5 high-to-low width");
         // Release direction 0 -> 1 (R5).
         hold(k, 1'b0);
         check(out_of(k) == 1'b0, "R6 polarity low", out_of(k), 0);
         for (int h = 1; h <= thr_of(k) + 2; h++) pulse_trial(k, h, "R5 low-to-high width");
         bounce_trial(k);
         bounce_trial(k);
         // R7: long steady input, well past the counter's wrap range.
         begin
            logic ref_v;
            int   moves;
            ref_v = out_of(k); moves = 0;
            repeat (80) begin
               @(negedge clk);
               if (out_of(k) != ref_v) moves++;
            end
            check(moves == 0, "R7 steady hold", moves, 0);
         end
         pulse_trial(k, thr_of(k), "R7 R2 latency after long hold");
      end

      // R1/R2: reset in the middle of operation with the inputs opposite the reset level.
      hold(0, 1'b0);
      hold(1, 1'b1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(clean0 == 1'b1, "R1 mid-run reset u0", clean0, 1);
      check(clean1 == 1'b0, "R1 mid-run reset u1", clean1, 0);
      rst = 1'b0;
      begin
         int e0, e1;
         e0 = -1; e1 = -1;
         for (int e = 1; e <= L0 + 6; e++) begin
            @(negedge clk);
            if (e0 < 0 && clean0 == 1'b0) e0 = e;
            if (e1 < 0 && clean1 == 1'b1) e1 = e;
         end
         check(e0 == L0, "R2 latency from reset u0", e0, L0);
         check(e1 == L1, "R2 latency from reset u1", e1, L1);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nvec++;
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule